// File: doc/BRIEF.md
# Transmit Checksum Inserter

The block sits in a transmit path between a frame source and the MAC. Per frame it first takes a five-word control header, then the frame itself as a byte stream that may be split into any number of fragments. Bytes are buffered until the end-of-packet beat. If the header asks for it, the block computes a 16-bit ones'-complement checksum over the frame from a chosen start offset to the last byte, with a seed from the header added in. It then replaces two bytes of the frame, starting at a chosen insertion offset, with that checksum in big-endian order. Only after that does it forward the frame.

Three configuration inputs govern every beat. A transmit-enable input discards all traffic while it is low. A jumbo permission and a tag permission decide whether frames just above standard size are dropped. A frame that outgrows the buffer is discarded whole. Every frame that goes out produces a one-cycle completion pulse and adds its length to a running byte total.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset the block accepts input (in_ready high), shows no output (out_valid low), holds tx_done low and tx_bytes at zero.
- R2: The header is five 32-bit words, one per hdr_valid cycle. Word 0 bit 0 turns insertion on. Word 1 bits 31:16 hold the start offset and bits 15:0 hold the insertion offset. Word 2 bits 15:0 hold the seed. Word 2 bits 31:16 and words 3 and 4 have no effect.
- R3: The checksum is the ones' complement of the end-around-carry sum of the seed and the big-endian 16-bit words formed from the frame bytes at the start offset through the last byte. An odd trailing byte is padded with a zero low byte. A start offset at or past the frame end gives a sum of the seed alone.
- R4: With insertion on, the checksum high byte replaces the byte at the insertion offset and the low byte replaces the next one, where those offsets fall inside the frame. Every other byte is forwarded unchanged. With insertion off, the frame is forwarded unchanged.
- R5: The first output byte appears only after the end-of-packet beat has been taken. in_ready is low for as long as a frame is being sent.
- R6: A beat taken while tx_enable is low is discarded and does not become part of any frame.
- R7: A frame longer than BUF_BYTES is discarded, including its remaining beats up to its end-of-packet beat. The next frame is handled normally. A frame of exactly BUF_BYTES bytes is kept.
- R8: With jumbo_ok and vlan_ok both low, frames of 1519 to 1522 bytes are dropped. Setting either input lets them through. Frames of 1518 bytes or fewer, and of 1523 bytes or more, are never dropped by this rule.
- R9: In the cycle after the last byte of a frame is taken, tx_done is high for one cycle and tx_bytes has grown by the frame length. A dropped frame changes neither.
- R10: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_enable | input | 1 | Low: input beats are discarded |
| jumbo_ok | input | 1 | Allows frames of 1519 to 1522 bytes |
| vlan_ok | input | 1 | Allows frames of 1519 to 1522 bytes |
| hdr_valid | input | 1 | One header word present |
| hdr_word | input | 32 | Header word |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes input bytes |
| in_byte | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes output byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| tx_done | output | 1 | One-cycle pulse per forwarded frame |
| tx_bytes | output | CNT_W | Running total of forwarded bytes |

## Verification
The bench builds the block with BUF_BYTES set to 1536 and leaves the other parameters at their defaults. That depth still holds every frame in the 1519 to 1522 byte band, so the size rule can be tested with and without each permission. It also puts the overflow boundary at a 1537-byte frame, which is short enough to send several times in one run. The checksum is tested with even and odd summed ranges, a start offset past the frame end, an insertion at offset zero and one at the final byte, and with output back-pressure.

// File: rtl/ckins_pkg.sv
package ckins_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_FOLD = 2'd1,
    ST_SEND = 2'd2
  } ck_state_e;

  // Two end-around folds bring any 32-bit partial sum into 16 bits.
  function automatic logic [15:0] ck_fold(input logic [31:0] v);
    logic [16:0] s1;
    logic [16:0] s2;
    s1 = {1'b0, v[15:0]} + {1'b0, v[31:16]};
    s2 = {1'b0, s1[15:0]} + {16'h0000, s1[16]};
    return s2[15:0];
  endfunction

endpackage

// File: rtl/ckins_rst_sync.sv
module ckins_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ckins_hdr.sv
module ckins_hdr #(
  parameter int HDR_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  input  logic [31:0] hdr_word,
  output logic        csum_on,
  output logic [15:0] start_off,
  output logic [15:0] ins_off,
  output logic [15:0] seed
);
  localparam int IDX_W = $clog2(HDR_WORDS);

  logic [IDX_W-1:0] widx_q, widx_d;
  logic             on_q, on_d;
  logic [15:0]      start_q, start_d, ins_q, ins_d, seed_q, seed_d;
  logic             hdr_unused;

  assign hdr_unused = ^hdr_word[31:1];

  always_comb begin
    widx_d  = widx_q;
    on_d    = on_q;
    start_d = start_q;
    ins_d   = ins_q;
    seed_d  = seed_q;
    if (hdr_valid) begin
      case (widx_q)
        IDX_W'(0): on_d = hdr_word[0];
        IDX_W'(1): begin
          start_d = hdr_word[31:16];
          ins_d   = hdr_word[15:0];
        end
        IDX_W'(2): seed_d = hdr_word[15:0];
        default: ;
      endcase
      widx_d = (widx_q == IDX_W'(HDR_WORDS - 1)) ? '0 : widx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q  <= '0;
      on_q    <= 1'b0;
      start_q <= '0;
      ins_q   <= '0;
      seed_q  <= '0;
    end else if (hdr_valid) begin
      widx_q  <= widx_d;
      on_q    <= on_d;
      start_q <= start_d;
      ins_q   <= ins_d;
      seed_q  <= seed_d;
    end
  end

  assign csum_on   = on_q;
  assign start_off = start_q;
  assign ins_off   = ins_q;
  assign seed      = seed_q;

  // R2: the word position never leaves the header length
  a_r2_word_index: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q < IDX_W'(HDR_WORDS));
endmodule

// File: rtl/ckins_acc.sv
module ckins_acc
  import ckins_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add_en,
  input  logic        hi_lane,
  input  logic [7:0]  add_byte,
  input  logic [15:0] seed,
  output logic [15:0] csum
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [15:0]      term;
  logic [ACC_W-1:0] seeded;

  assign term = hi_lane ? {add_byte, 8'h00} : {8'h00, add_byte};

  always_comb begin
    acc_d = acc_q;
    if (clr)         acc_d = '0;
    else if (add_en) acc_d = acc_q + ACC_W'(term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              acc_q <= '0;
    else if (clr || add_en)  acc_q <= acc_d;
  end

  assign seeded = acc_q + ACC_W'(seed);
  assign csum   = ~ck_fold(32'(seeded));
endmodule

// File: rtl/ckins_buf.sv
module ckins_buf #(
  parameter int DEPTH = 4096,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import ckins_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int CNT_W     = 32,
  parameter int STD_MAX   = 1518,
  parameter int TAG_MAX   = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             jumbo_ok,
  input  logic             vlan_ok,
  input  logic             hdr_valid,
  input  logic [31:0]      hdr_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             tx_done,
  output logic [CNT_W-1:0] tx_bytes
);
  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int LEN_W  = $clog2(BUF_BYTES + 1);

  logic rst_i_n;

  ck_state_e        st_q, st_d;
  logic [LEN_W-1:0] wr_cnt_q, wr_cnt_d, rd_ptr_q, rd_ptr_d, len_q, len_d;
  logic             drain_q, drain_d, on_q, on_d, done_q, done_d;
  logic [15:0]      ins_q, ins_d, csum_q, csum_d;
  logic [CNT_W-1:0] bytes_q, bytes_d;

  logic        h_on;
  logic [15:0] h_start, h_ins, h_seed;
  logic        acc_clr, acc_add, acc_hi;
  logic [15:0] acc_csum;
  logic        mem_we;
  logic [7:0]  mem_rdata;

  logic             beat, full, size_bad;
  logic [LEN_W-1:0] len_now;
  logic [16:0]      rd17, ins17;

  ckins_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  ckins_hdr #(.HDR_WORDS(5)) u_hdr (
    .clk(clk), .rst_n(rst_i_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .csum_on(h_on), .start_off(h_start), .ins_off(h_ins), .seed(h_seed)
  );

  ckins_acc #(.ACC_W(32)) u_acc (
    .clk(clk), .rst_n(rst_i_n), .clr(acc_clr), .add_en(acc_add),
    .hi_lane(acc_hi), .add_byte(in_byte), .seed(h_seed), .csum(acc_csum)
  );

  ckins_buf #(.DEPTH(BUF_BYTES), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .we(mem_we), .waddr(wr_cnt_q[ADDR_W-1:0]), .wdata(in_byte),
    .raddr(rd_ptr_q[ADDR_W-1:0]), .rdata(mem_rdata)
  );

  assign in_ready = (st_q == ST_FILL);
  assign beat     = in_valid && in_ready && tx_enable;
  assign full     = (wr_cnt_q == LEN_W'(BUF_BYTES));
  assign len_now  = wr_cnt_q + LEN_W'(1);
  assign size_bad = !jumbo_ok && !vlan_ok &&
                    (int'(len_now) > STD_MAX) && (int'(len_now) <= TAG_MAX);
  // A byte sits in the high lane when its distance from the start is even.
  assign acc_hi   = (wr_cnt_q[0] ^ h_start[0]) == 1'b0;

  always_comb begin
    st_d     = st_q;
    wr_cnt_d = wr_cnt_q;
    rd_ptr_d = rd_ptr_q;
    len_d    = len_q;
    drain_d  = drain_q;
    on_d     = on_q;
    ins_d    = ins_q;
    csum_d   = csum_q;
    bytes_d  = bytes_q;
    done_d   = 1'b0;
    mem_we   = 1'b0;
    acc_clr  = 1'b0;
    acc_add  = 1'b0;
    case (st_q)
      ST_FILL: begin
        if (beat) begin
          if (drain_q) begin
            drain_d = !in_last;
          end else if (full) begin
            wr_cnt_d = '0;
            acc_clr  = 1'b1;
            drain_d  = !in_last;
          end else begin
            mem_we  = 1'b1;
            acc_add = (17'(wr_cnt_q) >= {1'b0, h_start});
            if (in_last) begin
              wr_cnt_d = '0;
              if (size_bad) begin
                acc_clr = 1'b1;
              end else begin
                len_d = len_now;
                on_d  = h_on;
                ins_d = h_ins;
                st_d  = ST_FOLD;
              end
            end else begin
              wr_cnt_d = len_now;
            end
          end
        end
      end
      ST_FOLD: begin
        csum_d   = acc_csum;
        acc_clr  = 1'b1;
        rd_ptr_d = '0;
        st_d     = ST_SEND;
      end
      ST_SEND: begin
        if (out_ready) begin
          if (out_last) begin
            st_d    = ST_FILL;
            done_d  = 1'b1;
            bytes_d = bytes_q + CNT_W'(len_q);
          end else begin
            rd_ptr_d = rd_ptr_q + LEN_W'(1);
          end
        end
      end
      default: st_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_FILL;
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      len_q    <= '0;
      drain_q  <= 1'b0;
      on_q     <= 1'b0;
      ins_q    <= '0;
      csum_q   <= '0;
      bytes_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      done_q   <= done_d;
      if (beat) begin
        wr_cnt_q <= wr_cnt_d;
        drain_q  <= drain_d;
      end
      if (beat && in_last) begin
        len_q <= len_d;
        on_q  <= on_d;
        ins_q <= ins_d;
      end
      if (st_q == ST_FOLD) csum_q <= csum_d;
      if (st_q != ST_FILL) rd_ptr_q <= rd_ptr_d;
      if (done_d) bytes_q <= bytes_d;
    end
  end

  assign rd17      = 17'(rd_ptr_q);
  assign ins17     = {1'b0, ins_q};
  assign out_valid = (st_q == ST_SEND);
  assign out_last  = out_valid && (rd_ptr_q == len_q - LEN_W'(1));
  always_comb begin
    if (on_q && rd17 == ins17)                 out_byte = csum_q[15:8];
    else if (on_q && rd17 == ins17 + 17'd1)    out_byte = csum_q[7:0];
    else                                       out_byte = mem_rdata;
  end

  assign tx_done  = done_q;
  assign tx_bytes = bytes_q;

  // R5: output starts only two cycles after an end-of-packet beat
  a_r5_send_after_last: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(out_valid) |-> $past(in_valid && in_last, 2));

  // R10: a stalled output byte holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R9: a completed last byte yields the pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && out_ready && out_last) |=> tx_done);

  // R9: the byte total moves only with the pulse
  a_r9_total_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tx_done |-> $stable(tx_bytes));

  // R7: the fill count never passes the buffer depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_cnt_q <= LEN_W'(BUF_BYTES));
endmodule

// File: tb/tb_tx_csum_insert.sv
module tb_tx_csum_insert;
  localparam int BUF = 1536;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_enable, jumbo_ok, vlan_ok;
  logic        hdr_valid;
  logic [31:0] hdr_word;
  logic        in_valid, in_last, out_ready;
  logic [7:0]  in_byte;
  logic        in_ready, out_valid, out_last, tx_done;
  logic [7:0]  out_byte;
  logic [31:0] tx_bytes;

  tx_csum_insert #(.BUF_BYTES(BUF)) dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .jumbo_ok(jumbo_ok),
    .vlan_ok(vlan_ok), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .tx_done(tx_done),
    .tx_bytes(tx_bytes)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] bytes_exp = 0;
  logic [7:0] fr [0:1599];
  logic [7:0] xp [0:1599];
  logic [7:0] rx [0:1599];
  int rx_n;
  bit hold_bad, overlap_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_hdr(input bit en, input int start, input int ins, input int seed);
    for (int w = 0; w < 5; w++) begin
      hdr_valid = 1'b1;
      case (w)
        0: hdr_word = {31'h5a5a5a5a, en};
        1: hdr_word = {16'(start), 16'(ins)};
        2: hdr_word = {16'hbeef, 16'(seed)};
        default: hdr_word = 32'hffff_ffff;
      endcase
      @(negedge clk);
    end
    hdr_valid = 1'b0;
  endtask

  task automatic fill(input int len, input int pat);
    for (int i = 0; i < len; i++) fr[i] = 8'(i * 37 + pat);
  endtask

  task automatic send(input int len);
    bit took;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_byte  = fr[i];
      in_last  = (i == len - 1);
      do begin
        took = in_ready;
        @(negedge clk);
      end while (!took);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic recv(input bit stall);
    int guard = 0;
    bit fin = 0;
    bit held_v = 0;
    logic [7:0] held;
    rx_n = 0;
    hold_bad = 0;
    overlap_bad = 0;
    while (!fin && guard < 8000) begin
      out_ready = stall ? (guard % 3 == 2) : 1'b1;
      if (held_v && (!out_valid || out_byte != held)) hold_bad = 1;
      if (out_valid && in_ready) overlap_bad = 1;
      held_v = 0;
      if (out_valid && out_ready) begin
        if (rx_n < 1600) rx[rx_n] = out_byte;
        rx_n++;
        if (out_last) fin = 1;
      end else if (out_valid) begin
        held = out_byte;
        held_v = 1;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
  endtask

  function automatic logic [15:0] ref_csum(input int len, input int start, input int seed);
    logic [31:0] s = 32'(seed & 16'hffff);
    for (int i = start; i < len; i++)
      s += ((i - start) % 2 == 0) ? {16'h0, fr[i], 8'h00} : {24'h0, fr[i]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return ~s[15:0];
  endfunction

  // Send one frame and compare the forwarded copy against the reference.
  task automatic expect_frame(input int len, input bit en, input int start,
                              input int ins, input int seed, input bit stall,
                              input string req);
    logic [15:0] c;
    int bad = -1;
    put_hdr(en, start, ins, seed);
    send(len);
    c = ref_csum(len, start, seed);
    for (int i = 0; i < len; i++) xp[i] = fr[i];
    if (en && ins < len)     xp[ins] = c[15:8];
    if (en && ins + 1 < len) xp[ins + 1] = c[7:0];
    recv(stall);
    chk(rx_n == len, req, "frame length", rx_n, len);
    for (int i = 0; i < len && i < rx_n; i++)
      if (bad < 0 && rx[i] !== xp[i]) bad = i;
    chk(bad < 0, req, $sformatf("byte %0d", bad), (bad < 0) ? 0 : rx[bad],
        (bad < 0) ? 0 : xp[bad]);
    bytes_exp += 32'(len);
    chk(tx_done === 1'b1, "R9", "done pulse", tx_done, 1);
    chk(tx_bytes == bytes_exp, "R9", "byte total", tx_bytes, bytes_exp);
    chk(!overlap_bad, "R5", "input taken during output", overlap_bad, 0);
    if (stall) chk(!hold_bad, "R10", "stalled byte moved", hold_bad, 0);
    @(negedge clk);
    chk(tx_done === 1'b0, "R9", "pulse width", tx_done, 0);
  endtask

  task automatic expect_drop(input string req);
    int seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "output after dropped frame", seen, 0);
    chk(tx_bytes == bytes_exp, req, "byte total after drop", tx_bytes, bytes_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b1; jumbo_ok = 1'b0; vlan_ok = 1'b0;
    hdr_valid = 1'b0; hdr_word = '0; in_valid = 1'b0; in_last = 1'b0;
    in_byte = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: state after reset
    chk(in_ready === 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid === 1'b0, "R1", "out_valid", out_valid, 0);
    chk(tx_done === 1'b0, "R1", "tx_done", tx_done, 0);
    chk(tx_bytes == 0, "R1", "tx_bytes", tx_bytes, 0);

    // R3 R4: even summed range, header upper bits and words 3..4 junk (R2)
    fill(60, 3);
    expect_frame(60, 1, 14, 24, 16'h1234, 0, "R3");
    // R3 odd trailing byte, R10 back-pressure
    fill(61, 90);
    expect_frame(61, 1, 14, 40, 16'hfedc, 1, "R3");
    // R4 insertion off
    fill(40, 7);
    expect_frame(40, 0, 0, 4, 16'h0000, 0, "R4");
    // R4 insertion at offset zero, range from offset zero
    fill(20, 200);
    expect_frame(20, 1, 0, 0, 16'h00ff, 0, "R4");
    // R3 start past end, R4 insertion at final byte only
    fill(33, 55);
    expect_frame(33, 1, 200, 32, 16'h4321, 0, "R4");
    // R2 word-0 bit 0 decides insertion
    fill(26, 11);
    expect_frame(26, 1, 2, 10, 16'h0001, 1, "R2");

    // R6 transmit disabled discards beats
    tx_enable = 1'b0;
    fill(30, 1);
    put_hdr(1, 0, 2, 0);
    send(30);
    tx_enable = 1'b1;
    expect_drop("R6");
    fill(30, 77);
    expect_frame(30, 1, 0, 2, 16'h0, 0, "R6");

    // R7 one byte more than the buffer, then recovery
    fill(BUF + 1, 9);
    put_hdr(1, 14, 20, 0);
    send(BUF + 1);
    expect_drop("R7");
    fill(50, 13);
    expect_frame(50, 1, 14, 20, 16'h0bad, 0, "R7");
    fill(BUF, 21);
    expect_frame(BUF, 1, 14, 30, 16'h0, 0, "R7");

    // R8 size band
    fill(1519, 4);
    put_hdr(1, 14, 30, 0);
    send(1519);
    expect_drop("R8");
    fill(1522, 5);
    put_hdr(1, 14, 30, 0);
    send(1522);
    expect_drop("R8");
    fill(1518, 6);
    expect_frame(1518, 1, 14, 30, 16'h0, 0, "R8");
    fill(1523, 8);
    expect_frame(1523, 1, 14, 30, 16'h0, 0, "R8");
    vlan_ok = 1'b1;
    fill(1520, 12);
    expect_frame(1520, 1, 14, 30, 16'h0, 0, "R8");
    vlan_ok = 1'b0;
    jumbo_ok = 1'b1;
    fill(1521, 14);
    expect_frame(1521, 1, 14, 30, 16'h0, 0, "R8");
    jumbo_ok = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule